// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Run-Length Noise Filter

This block turns an asynchronous serial line into parallel bytes. The line carries frames made of one low start bit, eight data bits sent least significant first, and one high stop bit; between frames the line rests high. The receiver runs from a fast system clock. It builds its own sampling tick at eight times the bit rate with a fractional accumulator, so the average tick rate carries no rounding error even when the clock is not a whole multiple of it.

The line goes through a two-stage synchronizer and then a run-length filter. The filter changes its output level only after more than half a bit period of identical samples, so shorter pulses never reach the framing logic. A falling edge of the filtered line opens a frame and sets an in-frame state. While that state holds, low levels are read as zero data bits and never as a new start. The bits are gathered in a shift register, and a good stop bit copies the byte into a result register with a one-cycle strobe. A low stop bit drops the byte and raises a one-cycle error pulse. After that, the receiver waits for the line to go high again before it looks for the next start bit.

Top module: `uart_rx_oversampled`

## Requirements
- R1: A synchronous active-high reset clears the shift register, the result register (data_o = 0), the in-frame state and all counters; data_valid_o and frame_err_o read 0 after reset.
- R2: The sampling tick averages exactly OVS*BAUD ticks per second of a CLK_HZ clock through fractional accumulation, and never fires in two consecutive cycles; frames sent at the nominal rate are received intact.
- R3: On an idle (high) line, low pulses that cover at most OVS/2 samples produce neither data_valid_o nor frame_err_o.
- R4: Data bits are taken least significant first; data_o holds the last received byte and changes only in a cycle where data_valid_o is 1.
- R5: data_valid_o is high for exactly one system clock cycle per received byte.
- R6: A pulse of at most OVS/2 samples inside a run of equal line levels (start, data or stop bits) leaves the received byte unchanged.
- R7: A stop bit sampled low drops the byte: frame_err_o pulses for one cycle, data_valid_o stays 0, and data_o keeps its previous value.
- R8: After a framing error the receiver ignores a line held low until the line has been high for more than half a bit, then receives the next frame normally.
- R9: While a frame is in progress, zero data bits are never taken as a start; two frames sent back to back with no idle time between them are both received.
- R10: A reset asserted in the middle of a frame abandons it; no byte and no error is reported for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | DATA_W | Last byte received |
| data_valid_o | output | 1 | One-cycle strobe when data_o updates |
| frame_err_o | output | 1 | One-cycle pulse when a stop bit is low |

## Verification
The two functions that can fall in the same cycle are the filter throwing away a short pulse and the framing logic taking a bit sample. The filtered line lags the raw line by about five ticks, so a pulse placed early in a bit overlaps the tick on which the previous bit is read. The bench puts such pulses into runs of equal bits, including the stop bit and bits next to the start bit. It then judges the result from the received byte, the number of strobes and the number of error pulses.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int CLK_HZ = 12_000_000,
  parameter int BAUD   = 9600,
  parameter int OVS    = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int STEP  = BAUD * OVS;
  localparam int ACC_W = $clog2(CLK_HZ + STEP) + 1;
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);
  localparam logic [ACC_W-1:0] WRAP_V = ACC_W'(CLK_HZ);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;

  assign sum = acc + STEP_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (sum >= WRAP_V) begin
      acc  <= sum - WRAP_V;
      tick <= 1'b1;
    end else begin
      acc  <= sum;
      tick <= 1'b0;
    end
  end

  // R2: remainder stays below the wrap value
  a_r2_acc_bounded: assert property (@(posedge clk) disable iff (rst) acc < WRAP_V);
  // R2: tick is a single-cycle event when the clock is at least twice the tick rate
  a_r2_tick_spaced: assert property (@(posedge clk) disable iff (rst)
    (tick && (2 * STEP <= CLK_HZ)) |=> !tick);
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rx_glitch.sv
module uart_rx_glitch #(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic level
);
  localparam int ACCEPT = OVS / 2 + 1;
  localparam int RUN_W  = $clog2(ACCEPT + 1);
  localparam logic [RUN_W-1:0] ACCEPT_V = RUN_W'(ACCEPT);

  logic             cand, cand_n;
  logic [RUN_W-1:0] run, run_n;

  always_comb begin
    if (din != cand) begin
      cand_n = din;
      run_n  = RUN_W'(1);
    end else begin
      cand_n = cand;
      run_n  = (run == ACCEPT_V) ? run : run + RUN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand  <= 1'b1;
      run   <= ACCEPT_V;
      level <= 1'b1;
    end else if (tick) begin
      cand <= cand_n;
      run  <= run_n;
      if (run_n == ACCEPT_V) level <= cand_n;
    end
  end

  // R3: filtered level moves only on a sampling tick
  a_r3_level_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level));
  // R3: a new level is adopted only after a full confirming run
  a_r3_confirmed: assert property (@(posedge clk) disable iff (rst)
    $changed(level) |-> (cand == level && run == ACCEPT_V));
  a_r3_run_bounded: assert property (@(posedge clk) disable iff (rst)
    run <= ACCEPT_V);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  output logic [DATA_W-1:0] data_out,
  output logic              data_valid,
  output logic              frame_err
);
  localparam int FIRST = OVS + OVS / 2 - 1;
  localparam int CNT_W = $clog2(FIRST + 1);
  localparam int IDX_W = $clog2(DATA_W + 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              in_frame;

  assign in_frame = (st == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      data_out   <= '0;
      data_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      frame_err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (!line) begin
            st  <= ST_SHIFT;
            cnt <= CNT_W'(FIRST);
            idx <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (cnt != '0) begin
              cnt <= cnt - CNT_W'(1);
            end else begin
              cnt <= CNT_W'(OVS - 1);
              if (idx == IDX_W'(DATA_W)) begin
                if (line) begin
                  data_out   <= shreg;
                  data_valid <= 1'b1;
                  st         <= ST_IDLE;
                end else begin
                  frame_err <= 1'b1;
                  st        <= ST_HOLD;
                end
              end else begin
                shreg <= {line, shreg[DATA_W-1:1]};
                idx   <= idx + IDX_W'(1);
              end
            end
          end
        end
        ST_HOLD: begin
          if (line) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: strobe lasts one cycle
  a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);
  // R7: byte strobe and error pulse are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(data_valid && frame_err));
  // R8: an error leaves the receiver waiting for a high line
  a_r8_err_holds: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> (st == ST_HOLD));
  // R9: a completed byte closes the frame
  a_r9_frame_closed: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> !in_frame);
  // R4: result register moves only with its strobe
  a_r4_result_on_valid: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $changed(data_out)) |-> data_valid);
endmodule

// File: rtl/uart_rx_oversampled.sv
module uart_rx_oversampled #(
  parameter int CLK_HZ      = 12_000_000,
  parameter int BAUD        = 9600,
  parameter int OVS         = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              frame_err_o
);
  logic tick;
  logic rx_sync;
  logic rx_clean;

  uart_rx_tick #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_i),
    .dout(rx_sync)
  );

  uart_rx_glitch #(.OVS(OVS)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .din  (rx_sync),
    .level(rx_clean)
  );

  uart_rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .line      (rx_clean),
    .data_out  (data_o),
    .data_valid(data_valid_o),
    .frame_err (frame_err_o)
  );

  // R1: outputs are quiet in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!data_valid_o && !frame_err_o && data_o == '0));
endmodule

// File: tb/uart_rx_oversampled_tb.sv
module uart_rx_oversampled_tb;
  // 960 kHz nominal clock at 9600 baud: 100 cycles per bit, 12.5 per tick.
  // The accumulator makes the average tick rate exact; at 12 MHz a plain
  // count of 156 would run 0.16 % fast, the accumulator has no such error.
  localparam int CLK_HZ  = 960_000;
  localparam int BAUD    = 9600;
  localparam int BIT_CYC = CLK_HZ / BAUD;
  localparam int GL_LEN  = 40;  // at most 4 ticks: under half a bit
  localparam int NVEC    = 10;
  // {glitch frame-bit (15 = none), byte}
  localparam logic [11:0] VEC [NVEC] = '{
    12'hFA5, 12'hF5A, 12'h4FF, 12'h500, 12'h6F0,
    12'h20F, 12'h980, 12'h1FC, 12'h2C7, 12'hF3C
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx  = 1'b1;
  logic [7:0] data_o;
  logic       data_valid_o;
  logic       frame_err_o;

  int nchk = 0;
  int nerr = 0;
  int valid_cnt = 0;
  int ferr_cnt = 0;
  int long_cnt = 0;
  logic [7:0] last_data = 8'h00;
  logic [7:0] prev_data = 8'h00;
  logic prev_v = 1'b0;
  logic prev_f = 1'b0;

  always #10 clk = ~clk;

  uart_rx_oversampled #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .rx_i        (rx),
    .data_o      (data_o),
    .data_valid_o(data_valid_o),
    .frame_err_o (frame_err_o)
  );

  always @(negedge clk) begin
    if (data_valid_o) begin
      valid_cnt = valid_cnt + 1;
      prev_data = last_data;
      last_data = data_o;
    end
    if (frame_err_o) ferr_cnt = ferr_cnt + 1;
    if ((prev_v && data_valid_o) || (prev_f && frame_err_o)) long_cnt = long_cnt + 1;
    prev_v = data_valid_o;
    prev_f = frame_err_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nerr = nerr + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input int gl,
                            input int low_hold, input int gap);
    for (int j = 0; j < 10; j++) begin
      logic lvl;
      lvl = (j == 0) ? 1'b0 : (j == 9) ? stop : b[j-1];
      rx = lvl;
      if (j == gl) begin
        repeat (5) @(negedge clk);
        rx = ~lvl;
        repeat (GL_LEN) @(negedge clk);
        rx = lvl;
        repeat (BIT_CYC - 5 - GL_LEN) @(negedge clk);
      end else begin
        repeat (BIT_CYC) @(negedge clk);
      end
    end
    if (low_hold > 0) begin
      rx = 1'b0;
      repeat (low_hold) @(negedge clk);
    end
    rx = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    nerr = nerr + 1;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int v0, f0;
    logic [7:0] d0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(data_valid_o == 1'b0, "R1 valid", data_valid_o, 0);
    check(frame_err_o == 1'b0, "R1 ferr", frame_err_o, 0);
    check(data_o == 8'h00, "R1 data", data_o, 0);

    // R3: short low pulses on an idle line
    for (int k = 0; k < 5; k++) begin
      rx = 1'b0;
      repeat (GL_LEN - 4 * k) @(negedge clk);
      rx = 1'b1;
      repeat (BIT_CYC) @(negedge clk);
    end
    repeat (1200) @(negedge clk);
    check(valid_cnt == 0, "R3 no byte", valid_cnt, 0);
    check(ferr_cnt == 0, "R3 no error", ferr_cnt, 0);

    // Vector table: R2 rate, R4 order, R6 pulses inside equal runs
    for (int i = 0; i < NVEC; i++) begin
      v0 = valid_cnt;
      f0 = ferr_cnt;
      send_frame(VEC[i][7:0], 1'b1, int'(VEC[i][11:8]), 0, 150);
      check(valid_cnt == v0 + 1, "R2 one byte", valid_cnt - v0, 1);
      check(last_data == VEC[i][7:0],
            (VEC[i][11:8] == 4'hF) ? "R4 byte" : "R6 byte", last_data, VEC[i][7:0]);
      check(ferr_cnt == f0, "R6 no error", ferr_cnt - f0, 0);
    end
    check(long_cnt == 0, "R5 strobe width", long_cnt, 0);

    // R9: back-to-back frames, first all zero data bits
    v0 = valid_cnt;
    send_frame(8'h00, 1'b1, 15, 0, 0);
    send_frame(8'hE1, 1'b1, 15, 0, 150);
    check(valid_cnt == v0 + 2, "R9 two bytes", valid_cnt - v0, 2);
    check(prev_data == 8'h00, "R9 first byte", prev_data, 8'h00);
    check(last_data == 8'hE1, "R9 second byte", last_data, 8'hE1);

    // R7 and R8: low stop bit followed by a long low line
    v0 = valid_cnt;
    f0 = ferr_cnt;
    d0 = data_o;
    send_frame(8'h55, 1'b0, 15, 400, 150);
    check(ferr_cnt == f0 + 1, "R7 error pulse", ferr_cnt - f0, 1);
    check(valid_cnt == v0, "R7 no byte", valid_cnt - v0, 0);
    check(data_o == d0, "R7 data kept", data_o, d0);
    send_frame(8'h3C, 1'b1, 15, 0, 150);
    check(valid_cnt == v0 + 1, "R8 recovered", valid_cnt - v0, 1);
    check(last_data == 8'h3C, "R8 byte", last_data, 8'h3C);
    check(ferr_cnt == f0 + 1, "R8 no extra error", ferr_cnt - f0, 1);
    check(long_cnt == 0, "R5 pulse width", long_cnt, 0);

    // R10: reset in the middle of a frame
    v0 = valid_cnt;
    f0 = ferr_cnt;
    rx = 1'b0;
    repeat (280) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    rx = 1'b1;
    repeat (1500) @(negedge clk);
    check(valid_cnt == v0, "R10 no byte", valid_cnt - v0, 0);
    check(ferr_cnt == f0, "R10 no error", ferr_cnt - f0, 0);
    check(data_o == 8'h00, "R10 result cleared", data_o, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule